// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through Read Timing

This block is a first-in first-out buffer that joins two unrelated clock domains. Words are stored under a write clock and taken out under a read clock. The two clocks may run at any rates, with no required relationship between them. The write and read pointers cross between the domains as Gray code through two-flop synchronisers. The full flag is formed in the write domain and the empty flag in the read domain.

The read side has two timing modes, chosen by a mode input that is sampled only while master reset is high.

- **Standard mode:** the read-data output changes only when a read is performed.
- **Fall-through mode:** the head word moves to the output by itself. A word written into an empty FIFO reaches the output after a fixed read-clock latency, and a ready flag marks the output as valid.

The read-data output has an active-low output enable. When the output is disabled, the port floats.

Top module: `dual_clock_fifo`

## Requirements
- R1: With `wr_en_n` LOW and `full` LOW at a rising `wr_clk` edge, `wr_data` is stored. Words leave in the order they were stored, with none lost or repeated, while both clocks run at unrelated rates.
- R2: `full` is HIGH while the storage array holds `DEPTH` words. In standard mode these are `DEPTH` words written and not yet read. Writes attempted while `full` is HIGH are discarded and never reach the read side. `full` returns LOW once reads have drained the array.
- R3: In standard mode, `rd_data` keeps its value until a read, which is `rd_en_n` LOW at a rising `rd_clk` edge while `empty` is LOW. After that edge, `rd_data` holds the head word. `empty` is HIGH whenever no stored word remains, and `out_rdy` stays LOW.
- R4: A read attempted while `empty` is HIGH is ignored. The next word read afterwards is still the oldest unread word.
- R5: In fall-through mode, a word written into an empty FIFO is not yet valid after the second rising `rd_clk` edge that follows the write edge. It is on `rd_data`, with `out_rdy` HIGH, after the third such edge, and no read is needed for this.
- R6: In fall-through mode, `rd_data` and `out_rdy` hold steadily while `rd_en_n` is HIGH. A read (`rd_en_n` LOW while `out_rdy` is HIGH) presents the next stored word, or clears `out_rdy` if none remains. Reads while `out_rdy` is LOW are ignored. `empty` is always the inverse of `out_rdy`.
- R7: With `oe_n` HIGH, every bit of `rd_data` is high impedance. With `oe_n` LOW, `rd_data` drives the output register.
- R8: `mode_fwft` (1 = fall-through, 0 = standard) is captured only while `rst` is HIGH. Changing it after reset has no effect on read timing.
- R9: Reset leaves the following state:
  - both pointers at zero;
  - `full` LOW;
  - `empty` HIGH;
  - `out_rdy` LOW;
  - the output register cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst | input | 1 | Master reset, active high, sampled synchronously in each domain |
| mode_fwft | input | 1 | Read timing select, captured during reset (1 = fall-through) |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | DW | Read word, high impedance when `oe_n` is HIGH |
| full | output | 1 | Storage full (write domain) |
| empty | output | 1 | No word available to read (read domain) |
| out_rdy | output | 1 | Output word valid in fall-through mode |

## Verification
A write and a read can fall at nearly the same time in different domains. One case is a word entering while the last stored word is read out. The other is a read that frees a slot while the writer is stalled on `full`. In both cases the flags are updated from synchronised pointers that lag by two edges.

Randomised traffic is run in both modes. The write and read clocks have periods of 8 ns and 12 ns, and the edges of the two clocks never align. The enable rates push the FIFO repeatedly into both full and empty. Every word observed is compared with a queue model. That model records a write only when `full` was LOW at the accepting edge, and it removes a word only when a read is legal.

// File: rtl/dual_clock_fifo_pkg.sv
package dual_clock_fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchroniser for a Gray-coded pointer bus
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_mem.sv
// Simple dual-port storage; read port is registered so block RAM can be inferred
module dcf_mem #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    q <= '0;
    else if (re) q <= store[raddr];
  end
endmodule

// File: rtl/dcf_wctl.sv
// Write pointer and full flag (write domain)
module dcf_wctl #(
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rst,
  input  logic          wr_en_n,
  input  logic [AW:0]   rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wbin, wbin_nx;

  // full when write Gray equals read Gray with the top two bits inverted
  assign full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign we      = !wr_en_n && !full;
  assign wbin_nx = wbin + {{AW{1'b0}}, we};
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= (wbin_nx >> 1) ^ wbin_nx;
    end
  end

  // R2
  full_hold_chk: assert property (@(posedge wclk) disable iff (rst)
    full |=> $stable(wbin));
  // R1
  wr_advance_chk: assert property (@(posedge wclk) disable iff (rst)
    (!wr_en_n && !full) |=> (wbin == $past(wbin) + 1'b1));
endmodule

// File: rtl/dcf_rctl.sv
// Read pointer, empty flag and read-timing mode control (read domain)
module dcf_rctl
  import dual_clock_fifo_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          rst,
  input  logic          mode_i,
  input  logic          rd_en_n,
  input  logic [AW:0]   wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          out_rdy
);
  localparam int PW = AW + 1;

  rd_mode_e      mode_q;
  logic [PW-1:0] rbin, rbin_nx;
  logic          ptr_empty;

  assign ptr_empty = (rgray == wgray_s);
  assign re = (mode_q == MODE_FWFT) ? (!ptr_empty && (!out_rdy || !rd_en_n))
                                    : (!ptr_empty && !rd_en_n);
  assign rbin_nx = rbin + {{AW{1'b0}}, re};
  assign raddr   = rbin[AW-1:0];
  assign empty   = (mode_q == MODE_FWFT) ? !out_rdy : ptr_empty;

  always_ff @(posedge rclk) begin
    if (rst) begin
      mode_q  <= rd_mode_e'(mode_i);
      rbin    <= '0;
      rgray   <= '0;
      out_rdy <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= (rbin_nx >> 1) ^ rbin_nx;
      if (mode_q == MODE_FWFT) begin
        if (re)            out_rdy <= 1'b1;
        else if (!rd_en_n) out_rdy <= 1'b0;
      end
    end
  end

  // R4
  empty_hold_chk: assert property (@(posedge rclk) disable iff (rst)
    ptr_empty |=> $stable(rbin));
  // R3
  std_rdy_low_chk: assert property (@(posedge rclk) disable iff (rst)
    (mode_q == MODE_STD) |-> !out_rdy);
  // R6
  rdy_drop_chk: assert property (@(posedge rclk) disable iff (rst)
    ($fell(out_rdy) && !$past(rst)) |-> $past(!rd_en_n));
  // R8
  mode_hold_chk: assert property (@(posedge rclk) disable iff (rst)
    !rst |=> $stable(mode_q));
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 16
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst,
  input  logic          mode_fwft,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  input  logic          oe_n,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          out_rdy
);
  localparam int AW = $clog2(DEPTH);

  logic          we, re;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wgray_s, rgray_s;
  logic [DW-1:0] q_int;

  dcf_wctl #(.AW(AW)) u_wctl (
    .wclk(wr_clk), .rst(rst), .wr_en_n(wr_en_n), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .full(full)
  );

  dcf_sync #(.W(AW + 1)) u_w2r (
    .clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s)
  );

  dcf_sync #(.W(AW + 1)) u_r2w (
    .clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s)
  );

  dcf_rctl #(.AW(AW)) u_rctl (
    .rclk(rd_clk), .rst(rst), .mode_i(mode_fwft), .rd_en_n(rd_en_n),
    .wgray_s(wgray_s), .re(re), .raddr(raddr), .rgray(rgray),
    .empty(empty), .out_rdy(out_rdy)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rst), .re(re), .raddr(raddr), .q(q_int)
  );

  assign rd_data = oe_n ? {DW{1'bz}} : q_int;
endmodule

// File: tb/dual_clock_fifo_tb.sv
module dual_clock_fifo_tb;
  localparam int DW        = 18;
  localparam int DEPTH     = 16;
  localparam int WR_PERIOD = 8;
  localparam int RD_PERIOD = 12;

  logic          wr_clk, rd_clk, rst, mode_fwft, wr_en_n, rd_en_n, oe_n;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] rd_data;
  logic          full, empty, out_rdy;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model[$];
  bit wr_done;

  dual_clock_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .mode_fwft(mode_fwft),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n), .oe_n(oe_n),
    .rd_data(rd_data), .full(full), .empty(empty), .out_rdy(out_rdy)
  );

  // write edges at multiples of 4 ns, read edges at odd times: never aligned
  initial begin
    wr_clk = 0;
    forever #(WR_PERIOD / 2) wr_clk = ~wr_clk;
  end
  initial begin
    rd_clk = 0;
    #1;
    forever begin
      rd_clk = 1; #(RD_PERIOD / 2);
      rd_clk = 0; #(RD_PERIOD / 2);
    end
  end

  function automatic logic [DW-1:0] gen_word(int i);
    logic [31:0] v;
    v = (i * 32'd37 + 32'd5) ^ (i << 9) ^ 32'h2A55;
    return v[DW-1:0];
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic m);
    rst = 1; mode_fwft = m; wr_en_n = 1; rd_en_n = 1; oe_n = 0; wr_data = '0;
    repeat (3) @(posedge rd_clk);
    repeat (2) @(posedge wr_clk);
    #2 rst = 0;
    model.delete();
    #1 mode_fwft = ~m;  // R8: changed after reset, must have no effect
  endtask

  task automatic wr_one(logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = 0; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1;
  endtask

  task automatic std_directed();
    logic [DW-1:0] a, b;
    a = gen_word(1); b = gen_word(2);
    do_reset(1'b0);
    @(negedge rd_clk);
    chk_bit("R9 empty after reset", empty, 1'b1);
    chk_bit("R9 full after reset", full, 1'b0);
    chk_bit("R9 out_rdy after reset", out_rdy, 1'b0);
    chk("R9 rd_data after reset", rd_data, '0);
    // R4: reads while empty
    rd_en_n = 0;
    repeat (3) @(negedge rd_clk);
    rd_en_n = 1;
    chk("R4 rd_data after empty reads", rd_data, '0);
    wr_one(a);
    wr_one(b);
    repeat (6) @(negedge rd_clk);
    chk("R3 no read yet, output held", rd_data, '0);
    chk_bit("R3 empty low with data", empty, 1'b0);
    chk_bit("R8 mode flip ignored, out_rdy", out_rdy, 1'b0);
    rd_en_n = 0;
    @(negedge rd_clk);
    rd_en_n = 1;
    chk("R4 oldest word after empty reads", rd_data, a);
    repeat (3) @(negedge rd_clk);
    chk("R3 output holds without read", rd_data, a);
    oe_n = 1; #1;
    chk("R7 disabled output floats", rd_data, {DW{1'bz}});
    oe_n = 0; #1;
    chk("R7 enabled output drives", rd_data, a);
    rd_en_n = 0;
    @(negedge rd_clk);
    rd_en_n = 1;
    chk("R3 second read", rd_data, b);
    chk_bit("R3 empty after last read", empty, 1'b1);
  endtask

  task automatic full_directed();
    do_reset(1'b0);
    @(negedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0 || i == DEPTH - 1) chk_bit("R2 full low before fill", full, 1'b0);
      wr_en_n = 0; wr_data = gen_word(100 + i);
      model.push_back(wr_data);
      @(negedge wr_clk);
    end
    chk_bit("R2 full after DEPTH writes", full, 1'b1);
    for (int i = 0; i < 3; i++) begin
      wr_data = gen_word(900 + i);
      @(negedge wr_clk);
    end
    wr_en_n = 1;
    chk_bit("R2 full holds after blocked writes", full, 1'b1);
    repeat (4) @(negedge rd_clk);
    rd_en_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge rd_clk);
      chk("R2 drained word", rd_data, model.pop_front());
    end
    rd_en_n = 1;
    chk_bit("R2 empty after drain, blocked writes absent", empty, 1'b1);
    repeat (5) @(negedge wr_clk);
    chk_bit("R2 full cleared after drain", full, 1'b0);
    repeat (4) @(negedge rd_clk);
    chk_bit("R2 blocked words never appear", empty, 1'b1);
  endtask

  task automatic fwft_directed();
    logic [DW-1:0] b, c, d, e;
    b = gen_word(11); c = gen_word(12); d = gen_word(13); e = gen_word(14);
    do_reset(1'b1);
    @(negedge rd_clk);
    chk_bit("R9 fwft out_rdy after reset", out_rdy, 1'b0);
    chk_bit("R9 fwft empty after reset", empty, 1'b1);
    @(negedge wr_clk);
    wr_en_n = 0; wr_data = b;
    @(posedge wr_clk);
    fork
      begin @(negedge wr_clk); wr_en_n = 1; end
    join_none
    repeat (2) @(posedge rd_clk);
    @(negedge rd_clk);
    chk_bit("R5 not ready after two read edges", out_rdy, 1'b0);
    @(posedge rd_clk);
    @(negedge rd_clk);
    chk_bit("R5 ready after third read edge", out_rdy, 1'b1);
    chk("R5 word fell through", rd_data, b);
    chk_bit("R6 empty is inverse of ready", empty, 1'b0);
    wr_one(c);
    wr_one(d);
    repeat (6) @(negedge rd_clk);
    chk("R6 output held without read", rd_data, b);
    rd_en_n = 0;
    @(negedge rd_clk);
    chk("R6 read advances to next", rd_data, c);
    @(negedge rd_clk);
    chk("R6 read advances again", rd_data, d);
    chk_bit("R6 still ready", out_rdy, 1'b1);
    @(negedge rd_clk);
    chk_bit("R6 ready drops when none remain", out_rdy, 1'b0);
    chk_bit("R6 empty follows ready", empty, 1'b1);
    repeat (2) @(negedge rd_clk);
    rd_en_n = 1;
    wr_one(e);
    repeat (6) @(negedge rd_clk);
    chk("R6 reads while not ready ignored", rd_data, e);
    chk_bit("R6 ready after refill", out_rdy, 1'b1);
  endtask

  task automatic rand_run(logic m, int n);
    do_reset(m);
    wr_done = 0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          @(negedge wr_clk);
          if ($urandom % 4 != 0) begin
            wr_en_n = 0;
            wr_data = DW'($urandom);
            if (!full) model.push_back(wr_data);
          end else begin
            wr_en_n = 1;
          end
        end
        @(negedge wr_clk);
        wr_en_n = 1;
        wr_done = 1;
      end
      begin
        bit pend;
        logic [DW-1:0] exp_w;
        pend = 0;
        exp_w = '0;
        while (!(wr_done && model.size() == 0 && !pend)) begin
          @(negedge rd_clk);
          if (m == 1'b0) begin
            if (pend) chk("R1 random std order", rd_data, exp_w);
            pend = 0;
            if ($urandom % 2 == 0) begin
              rd_en_n = 0;
              if (!empty) begin
                exp_w = model.pop_front();
                pend = 1;
              end
            end else begin
              rd_en_n = 1;
            end
          end else begin
            if (out_rdy) chk("R1 random fwft order", rd_data, model[0]);
            if ($urandom % 2 == 0) begin
              rd_en_n = 0;
              if (out_rdy) void'(model.pop_front());
            end else begin
              rd_en_n = 1;
            end
          end
        end
        rd_en_n = 1;
      end
    join
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    n_tests++;
    n_fail++;
    $display("FAIL R1 watchdog: actual hang expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1DC0FF));
    rst = 1; mode_fwft = 0; wr_en_n = 1; rd_en_n = 1; oe_n = 0; wr_data = '0;
    std_directed();
    full_directed();
    fwft_directed();
    rand_run(1'b0, 400);
    rand_run(1'b1, 400);
    summary();
    $finish;
  end
endmodule